// File: doc/BRIEF.md
# Embedded-Sync TRS Decoder

This block sits at the front of a video input path. It takes a clocked stream of digital video samples in which the synchronisation is carried inside the data as timing reference sequences. Each sequence is a word of all ones, then two words of all zeros, then a status word. Only cycles on which the data-valid input is high carry a sample. The block finds these sequences and reads the horizontal-blanking, vertical-blanking and field bits from each status word. From them it rebuilds level flags that follow the picture.

Picture samples, meaning words that arrive while both blanking flags are clear and that are not part of a sequence, are forwarded with a valid strobe. Two markers go with them: a start-of-frame marker on the first picture sample after vertical blanking ends, and an end-of-line marker on the last picture sample before the next sequence. The sample width is 8 or 10 bits, set by a parameter. In 10-bit mode the two least significant bits of sequence and status words are ignored, so 8-bit codes still decode.

Top module: `emb_sync_decoder`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_hblank and out_vblank are 1, and out_field, out_active, out_valid, out_sof and out_eol are 0.
- R2: A status word is recognised when three valid words whose upper eight bits are 0xFF, 0x00 and 0x00 come before it. In the upper eight bits of the status word, bit 4 is H (horizontal blanking), bit 5 is V (vertical blanking) and bit 6 is F (field 1). These values appear on out_hblank, out_vblank and out_field in the cycle after the status word is clocked in.
- R3: With DATA_W=10, bits 1:0 of every word take no part in matching or decoding. Bits 3:0 and bit 7 of the upper eight bits of the status word are never examined.
- R4: A cycle with in_valid low neither advances nor restarts the sequence matcher. Its data is not forwarded, and it changes none of the flags.
- R5: A word that breaks a partial sequence restarts the matcher and leaves the flags unchanged. If the breaking word is 0xFF, it begins a new sequence.
- R6: The flags keep their values from one status word to the next.
- R7: A valid word is a picture sample when it is not a status word, its upper eight bits are neither 0xFF nor 0x00, and H and V are both 0. It appears on out_data with out_valid high in the cycle after the next valid word is clocked in.
- R8: out_eol is high with a picture sample when the next valid word has upper bits 0xFF.
- R9: out_sof is high with the first picture sample after a status word that changes V from 1 to 0.
- R10: out_active equals the NOR of out_hblank and out_vblank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample qualifier |
| in_data | input | DATA_W | Video sample |
| out_valid | output | 1 | Picture sample strobe |
| out_data | output | DATA_W | Forwarded picture sample |
| out_sof | output | 1 | First picture sample of a frame |
| out_eol | output | 1 | Last picture sample of a line |
| out_hblank | output | 1 | Horizontal blanking flag |
| out_vblank | output | 1 | Vertical blanking flag |
| out_field | output | 1 | Field 1 flag |
| out_active | output | 1 | Both blanking flags clear |

## Verification
The hardest case to reach is a run where the matcher state and the valid gaps interact. A partial sequence can sit open across idle cycles whose data looks like a complete sequence. A second 0xFF can arrive in the middle of a sequence, or a sequence can break just before a real one starts. The stimulus builds these on purpose. It sends full sequence patterns with in_valid low, breaks sequences after one and two words, repeats the leading 0xFF, and puts noise in the ignored status bits and in the two low bits. A behavioural model that keeps a history of the last three codes is compared against the outputs on every clock.

// File: rtl/emb_sync_pkg.sv
package emb_sync_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_ONES = 8'hFF;
  localparam logic [CODE_W-1:0] CODE_ZERO = 8'h00;
  localparam int H_POS = 4;
  localparam int V_POS = 5;
  localparam int F_POS = 6;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_ONE   = 2'd1,
    M_TWO   = 2'd2,
    M_THREE = 2'd3
  } match_st_t;

  typedef struct packed {
    logic h;
    logic v;
    logic f;
  } sync_flags_t;
endpackage

// File: rtl/trs_matcher.sv
module trs_matcher
  import emb_sync_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              is_ones,
  output logic              is_zero,
  output logic              xyz_hit,
  output sync_flags_t       xyz_flags
);
  localparam int DROP = DATA_W - CODE_W;

  logic [CODE_W-1:0] code;
  match_st_t         st_q, st_d;

  generate
    if (DROP > 0) begin : g_wide
      assign code = in_data[DATA_W-1 -: CODE_W];
    end else begin : g_narrow
      assign code = in_data[CODE_W-1:0];
    end
  endgenerate

  assign is_ones = (code == CODE_ONES);
  assign is_zero = (code == CODE_ZERO);
  assign xyz_hit = in_valid && (st_q == M_THREE);
  assign xyz_flags.h = code[H_POS];
  assign xyz_flags.v = code[V_POS];
  assign xyz_flags.f = code[F_POS];

  always_comb begin
    st_d = st_q;
    if (in_valid) begin
      unique case (st_q)
        M_IDLE:  st_d = is_ones ? M_ONE : M_IDLE;
        M_ONE:   st_d = is_zero ? M_TWO : (is_ones ? M_ONE : M_IDLE);
        M_TWO:   st_d = is_zero ? M_THREE : (is_ones ? M_ONE : M_IDLE);
        M_THREE: st_d = M_IDLE;
        default: st_d = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= M_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/flag_tracker.sv
module flag_tracker
  import emb_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        xyz_hit,
  input  sync_flags_t xyz_flags,
  output sync_flags_t flags,
  output logic        frame_arm
);
  sync_flags_t flags_q;

  assign flags     = flags_q;
  assign frame_arm = xyz_hit && flags_q.v && !xyz_flags.v;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q.h <= 1'b1;
      flags_q.v <= 1'b1;
      flags_q.f <= 1'b0;
    end else if (xyz_hit) begin
      flags_q <= xyz_flags;
    end
  end
endmodule

// File: rtl/pixel_stage.sv
module pixel_stage #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take_pixel,
  input  logic              next_ones,
  input  logic              frame_arm,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eol
);
  logic              held_q;
  logic [DATA_W-1:0] held_data_q;
  logic              held_sof_q;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q      <= 1'b0;
      held_data_q <= '0;
      held_sof_q  <= 1'b0;
      armed_q     <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sof     <= 1'b0;
      out_eol     <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      if (frame_arm) armed_q <= 1'b1;
      if (in_valid && held_q) begin
        out_valid <= 1'b1;
        out_data  <= held_data_q;
        out_sof   <= held_sof_q;
        out_eol   <= next_ones;
        held_q    <= 1'b0;
      end
      if (take_pixel) begin
        held_q      <= 1'b1;
        held_data_q <= in_data;
        held_sof_q  <= armed_q;
        armed_q     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/emb_sync_decoder.sv
module emb_sync_decoder
  import emb_sync_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eol,
  output logic              out_hblank,
  output logic              out_vblank,
  output logic              out_field,
  output logic              out_active
);
  logic        is_ones;
  logic        is_zero;
  logic        xyz_hit;
  logic        frame_arm;
  logic        take_pixel;
  sync_flags_t xyz_flags;
  sync_flags_t flags;

  trs_matcher #(.DATA_W(DATA_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .is_ones   (is_ones),
    .is_zero   (is_zero),
    .xyz_hit   (xyz_hit),
    .xyz_flags (xyz_flags)
  );

  flag_tracker u_flags (
    .clk       (clk),
    .rst       (rst),
    .xyz_hit   (xyz_hit),
    .xyz_flags (xyz_flags),
    .flags     (flags),
    .frame_arm (frame_arm)
  );

  assign take_pixel = in_valid && !xyz_hit && !flags.h && !flags.v
                      && !is_ones && !is_zero;

  pixel_stage #(.DATA_W(DATA_W)) u_pix (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .take_pixel (take_pixel),
    .next_ones  (is_ones),
    .frame_arm  (frame_arm),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_sof    (out_sof),
    .out_eol    (out_eol)
  );

  assign out_hblank = flags.h;
  assign out_vblank = flags.v;
  assign out_field  = flags.f;
  assign out_active = !flags.h && !flags.v;
endmodule

// File: rtl/emb_sync_checker.sv
module emb_sync_checker (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic out_sof,
  input logic out_eol,
  input logic out_hblank,
  input logic out_vblank,
  input logic out_field,
  input logic out_active
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (out_hblank && out_vblank && !out_field && !out_valid && !out_sof && !out_eol));

  p_gap_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_hblank) && $stable(out_vblank) && $stable(out_field)));

  p_pixel_in_active_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_active);

  p_eol_with_pixel_r8: assert property (@(posedge clk) disable iff (rst)
    out_eol |-> out_valid);

  p_sof_with_pixel_r9: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
endmodule

bind emb_sync_decoder emb_sync_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_sof    (out_sof),
  .out_eol    (out_eol),
  .out_hblank (out_hblank),
  .out_vblank (out_vblank),
  .out_field  (out_field),
  .out_active (out_active)
);

// File: tb/emb_sync_decoder_test.sv
module emb_sync_decoder_test;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_sof, out_eol, out_hblank, out_vblank, out_field, out_active;
  logic [DW-1:0] out_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  emb_sync_decoder #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol),
    .out_hblank(out_hblank), .out_vblank(out_vblank), .out_field(out_field),
    .out_active(out_active)
  );

  // behavioural reference model
  int mh = 1, mv = 1, mf = 0;
  int hist[$];
  int st_full = 0, st_sof = 0, pend = 0;
  int st_data = 0;
  int e_valid = 0, e_data = 0, e_sof = 0, e_eol = 0;
  int sof_seen = 0, eol_seen = 0;

  always @(posedge clk) begin
    int code;
    bit is_xyz;
    e_valid = 0; e_sof = 0; e_eol = 0;
    if (rst) begin
      mh = 1; mv = 1; mf = 0; hist.delete();
      st_full = 0; st_sof = 0; pend = 0;
    end else if (in_valid) begin
      code = int'(in_data) >> 2;
      is_xyz = (hist.size() == 3) && hist[0] == 255 && hist[1] == 0 && hist[2] == 0;
      if (st_full != 0) begin
        e_valid = 1; e_data = st_data; e_sof = st_sof; e_eol = (code == 255) ? 1 : 0;
        st_full = 0;
      end
      if (is_xyz) begin
        if (mv == 1 && ((code >> 5) & 1) == 0) pend = 1;
        mh = (code >> 4) & 1; mv = (code >> 5) & 1; mf = (code >> 6) & 1;
        hist.delete();
      end else begin
        hist.push_back(code);
        if (hist.size() > 3) void'(hist.pop_front());
        if (mh == 0 && mv == 0 && code != 255 && code != 0) begin
          st_full = 1; st_data = int'(in_data); st_sof = pend; pend = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid == e_valid[0], "R7 out_valid", out_valid, e_valid);
      if (e_valid != 0) chk(int'(out_data) == e_data, "R7 out_data", out_data, e_data);
      chk(out_eol == e_eol[0], "R8 out_eol", out_eol, e_eol);
      chk(out_sof == e_sof[0], "R9 out_sof", out_sof, e_sof);
      chk({out_hblank, out_vblank, out_field} == {mh[0], mv[0], mf[0]}, "R2 flags",
          {out_hblank, out_vblank, out_field}, {mh[0], mv[0], mf[0]});
      chk(out_active == (!out_hblank && !out_vblank), "R10 out_active", out_active,
          !out_hblank && !out_vblank);
      if (out_sof) sof_seen++;
      if (out_eol) eol_seen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic put(input logic [7:0] code, input logic [1:0] lsb);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = {code, lsb};
  endtask

  task automatic gap(input int n, input logic [7:0] code);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data = {code, 2'($urandom)};
    end
  endtask

  function automatic logic [7:0] xyz(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, 4'h0};
  endfunction

  task automatic trs(input bit f, input bit v, input bit h);
    put(8'hFF, 2'($urandom)); put(8'h00, 2'($urandom));
    put(8'h00, 2'($urandom)); put(xyz(f, v, h), 2'($urandom));
  endtask

  task automatic pix(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      put(8'(1 + ($urandom % 254)), 2'($urandom));
      if (gaps && ($urandom % 3 == 0)) gap(1 + $urandom % 2, 8'(1 + $urandom % 254));
    end
  endtask

  task automatic line(input bit f, input bit v, input int n, input bit gaps);
    trs(f, v, 1'b1); pix(4, 1'b0);
    trs(f, v, 1'b0); pix(n, gaps);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_hblank && out_vblank && !out_field && !out_active && !out_valid && !out_sof && !out_eol,
        "R1 reset state", {out_hblank, out_vblank, out_field, out_valid}, 4'b1100);
    @(negedge clk); rst = 1'b0;
    chk(out_hblank && out_vblank && !out_valid, "R1 after reset", {out_hblank, out_vblank}, 2'b11);

    // vertical blanking lines, then an active frame
    line(1'b0, 1'b1, 6, 1'b0);
    line(1'b0, 1'b1, 6, 1'b0);
    for (int l = 0; l < 4; l++) line(1'b0, 1'b0, 8 + l, l[0]);
    trs(1'b0, 1'b0, 1'b1);
    gap(1, 8'h10);
    chk(sof_seen == 1, "R9 one sof per frame", sof_seen, 1);
    chk(eol_seen == 4, "R8 eol per active line", eol_seen, 4);
    chk(out_hblank && !out_vblank, "R2 end-of-line code decoded", {out_hblank, out_vblank}, 2'b10);

    // R3: noise in ignored status bits and low bits
    put(8'hFF, 2'b10); put(8'h00, 2'b11); put(8'h00, 2'b01); put(8'h4F, 2'b11);
    gap(1, 8'h20);
    chk(!out_hblank && !out_vblank && out_field, "R3 ignored bits", {out_hblank, out_vblank, out_field}, 3'b001);
    pix(10, 1'b1);
    gap(1, 8'h30);
    chk(!out_hblank && !out_vblank && out_field, "R6 flags held over pixels",
        {out_hblank, out_vblank, out_field}, 3'b001);

    // R4: a whole sequence presented while in_valid is low
    gap(1, 8'hFF); gap(2, 8'h00); gap(1, xyz(1'b0, 1'b1, 1'b1));
    chk(!out_hblank && !out_vblank && out_field && !out_valid, "R4 invalid cycles ignored",
        {out_hblank, out_vblank, out_valid}, 3'b000);
    // partial sequence spanning invalid gaps completes on valid words
    put(8'hFF, 2'b00); gap(2, 8'h55); put(8'h00, 2'b01); gap(1, 8'hFF); put(8'h00, 2'b10);
    gap(3, 8'h00); put(xyz(1'b1, 1'b0, 1'b1), 2'b00);
    gap(1, 8'h11);
    chk(out_hblank && !out_vblank, "R4 matcher held across gaps", {out_hblank, out_vblank}, 2'b10);

    // R5: broken sequences
    put(8'hFF, 2'b00); put(8'h00, 2'b00); put(8'h42, 2'b00); put(xyz(1'b0, 1'b1, 1'b0), 2'b00);
    gap(1, 8'h12);
    chk(out_hblank && !out_vblank && out_field, "R5 break after two words", {out_hblank, out_vblank, out_field}, 3'b101);
    put(8'hFF, 2'b00); put(8'h37, 2'b00); put(8'h00, 2'b00); put(8'h00, 2'b00); put(8'hB0, 2'b00);
    gap(1, 8'h13);
    chk(out_hblank && !out_vblank && out_field, "R5 break after one word", {out_hblank, out_vblank, out_field}, 3'b101);
    put(8'hFF, 2'b00); put(8'h00, 2'b00); put(8'hFF, 2'b01); put(8'h00, 2'b00); put(8'h00, 2'b00);
    put(xyz(1'b0, 1'b1, 1'b1), 2'b00);
    gap(1, 8'h14);
    chk(out_hblank && out_vblank && !out_field, "R5 restart on ones word", {out_hblank, out_vblank, out_field}, 3'b110);

    // second frame with gaps everywhere
    line(1'b1, 1'b1, 5, 1'b1);
    for (int l = 0; l < 3; l++) line(1'b1, 1'b0, 6, 1'b1);
    trs(1'b1, 1'b1, 1'b1);
    gap(2, 8'h15);
    chk(sof_seen == 2, "R9 sof on second frame", sof_seen, 2);

    // reset in mid stream
    put(8'hFF, 2'b00); put(8'h00, 2'b00);
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    chk(out_hblank && out_vblank && !out_field && !out_valid, "R1 mid-stream reset",
        {out_hblank, out_vblank, out_field}, 3'b110);
    line(1'b0, 1'b0, 5, 1'b0);
    trs(1'b0, 1'b1, 1'b1);
    gap(3, 8'h16);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule